// File: doc/BRIEF.md
# Hardwired Micro-Operation Sequencer

This block is the control unit and small register datapath of a one-accumulator processor. It holds an address register (MAR), a buffer register (MBR), a program counter, an instruction register and one working register. Each clock edge carries out one group of register transfers. A one-hot timing counter and a one-hot opcode decoder select that group. A cycle-state register moves the machine through four cycles: instruction fetch, operand-address indirection, execution and interrupt entry. The block also has a halted state.

The block drives a single-port memory. The address comes straight from MAR and the write data straight from MBR. There is one read strobe and one write strobe. Read data must be valid in the cycle in which the strobe is high: the cycle after MAR was loaded. Writes take effect at the clock edge that ends the strobe cycle. An interrupt request is sampled at the end of each instruction. When it is taken, the return address is written to a fixed save location and control moves to a fixed service entry point. The program counter and the working register are brought out so that the system can observe them.

Top module: `hw_sequencer`

## Requirements
- R1: Synchronous reset clears the program counter, the working register and both memory strobes, and leaves the block not halted. The first fetch after reset reads address 0.
- R2: A fetch takes three cycles. In cycle 1, MAR is loaded from PC. In cycle 2, a read is made at that address and PC is incremented. In cycle 3, the instruction register is loaded. The read strobe is high only in cycle 2.
- R3: An instruction word has the opcode in bits 15:12, an indirect flag in bit 11 and an address in bits 10:0. The opcodes are 0 = HALT, 1 = ADD, 2 = ISZ and 3 = BSA. Opcodes 4 to 15 are no-operations that end after the fetch, whatever their flag and address bits.
- R4: ADD X reads X and adds its value to the working register, modulo 2^16. The execute cycle takes three cycles.
- R5: ISZ X reads X, increments it and writes the result back to X. If the result is zero, the next instruction is skipped. The execute cycle takes four cycles.
- R6: BSA X writes the address of the following instruction, zero-extended, to X and continues execution at X+1. The execute cycle takes three cycles.
- R7: When the indirect flag of ADD, ISZ or BSA is set, a three-cycle indirect cycle reads the word at the address field. Bits 10:0 of that word then become the operand address. Its upper bits are ignored.
- R8: At the end of an instruction, an asserted request with interrupts enabled starts a three-cycle interrupt cycle. This cycle writes PC to address 0x7FE and sets PC to 0x7C0. Fetching then resumes there.
- R9: Interrupts are enabled after reset. They are disabled on entry to the interrupt cycle, so a request held high is taken only once. They are enabled again at the end of an instruction during which the request is low.
- R10: HALT stops the machine once its fetch ends. While halted, PC holds, no memory access is made and the request is ignored, until reset.
- R11: A read and a write never occur in the same cycle. A read strobe is never followed by another read strobe, and a write strobe is never followed by another write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq | input | 1 | Interrupt request, level |
| mem_addr | output | 11 | Memory address (MAR) |
| mem_wdata | output | 16 | Memory write data (MBR) |
| mem_rdata | input | 16 | Memory read data, valid in the strobe cycle |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| pc | output | 11 | Program counter |
| acc | output | 16 | Working register |
| halted | output | 1 | High while the machine is halted |

## Verification
A wrong timing slot or cycle state shows up at once in the memory strobes: a read goes to the wrong address, or a strobe falls in the wrong cycle. The total cycle count to the halted state is fixed by the instruction mix, so every extra or missing slot shifts when the halted signal rises. A wrong operand-address or skip decision shows up in the working register, in the data words and in the final PC. Interrupt enable errors show up as a missing or repeated write to the save location, and as a doubled or missing accumulation in the service code.

// File: rtl/hw_sequencer.sv
module hw_sequencer #(
  parameter int AW = 11,
  parameter int OPW = 4,
  parameter logic [AW-1:0] SAVE_ADDR = 11'h7FE,
  parameter logic [AW-1:0] ISR_ADDR = 11'h7C0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irq,
  output logic [AW-1:0] mem_addr,
  output logic [OPW+AW:0] mem_wdata,
  input  logic [OPW+AW:0] mem_rdata,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] pc,
  output logic [OPW+AW:0] acc,
  output logic          halted
);
  localparam int DW = OPW + 1 + AW;
  localparam int NOPS = 1 << OPW;
  localparam int NSLOT = 4;
  localparam logic [OPW-1:0] OP_HALT = '0;
  localparam logic [OPW-1:0] OP_ADD = OPW'(1);
  localparam logic [OPW-1:0] OP_ISZ = OPW'(2);
  localparam logic [OPW-1:0] OP_BSA = OPW'(3);

  typedef enum logic [2:0] {S_FETCH, S_IND, S_EXEC, S_INTR, S_HALT} cyc_t;

  cyc_t state, st_n;
  logic [NSLOT-1:0] t;
  logic [AW-1:0] mar, pc_q;
  logic [DW-1:0] mbr, ir, r1;
  logic ie, last;

  wire [OPW-1:0] op_ir = ir[DW-1 -: OPW];
  wire [OPW-1:0] op_nx = mbr[DW-1 -: OPW];
  wire [NOPS-1:0] opl = {{(NOPS-1){1'b0}}, 1'b1} << op_ir;
  wire add = opl[OP_ADD];
  wire isz = opl[OP_ISZ];
  wire bsa = opl[OP_BSA];
  wire memref = add | isz | bsa;
  wire halt_nx = op_nx == OP_HALT;
  wire memref_nx = (op_nx == OP_ADD) | (op_nx == OP_ISZ) | (op_nx == OP_BSA);

  wire fe = state == S_FETCH;
  wire id = state == S_IND;
  wire ex = state == S_EXEC;
  wire it = state == S_INTR;

  wire mar_pc   = fe & t[0];
  wire mar_ir   = (id | ex & memref) & t[0];
  wire mar_save = it & t[1];
  wire rd       = (fe | id | ex & (add | isz)) & t[1];
  wire mbr_pc   = (it | ex & bsa) & t[0];
  wire mbr_inc  = ex & isz & t[2];
  wire ir_all   = fe & t[2];
  wire ir_addr  = id & t[2];
  wire pc_isr   = it & t[1];
  wire pc_jump  = ex & bsa & t[1];
  wire pc_inc   = fe & t[1] | ex & bsa & t[2] | ex & isz & t[3] & (mbr == '0);
  wire acc_add  = ex & add & t[2];
  wire wr       = ex & isz & t[3] | ex & bsa & t[1] | it & t[2];

  wire end_instr = (fe & t[2] & ~memref_nx & ~halt_nx) |
                   (ex & t[2] & (add | bsa)) | (ex & t[3] & isz);
  wire take_int = end_instr & irq & ie;

  always_comb begin
    st_n = state;
    last = 1'b0;
    case (state)
      S_FETCH: if (t[2]) begin
        last = 1'b1;
        if (halt_nx) st_n = S_HALT;
        else if (memref_nx) st_n = mbr[AW] ? S_IND : S_EXEC;
        else st_n = take_int ? S_INTR : S_FETCH;
      end
      S_IND: if (t[2]) begin
        last = 1'b1;
        st_n = S_EXEC;
      end
      S_EXEC: if (end_instr) begin
        last = 1'b1;
        st_n = take_int ? S_INTR : S_FETCH;
      end
      S_INTR: if (t[2]) begin
        last = 1'b1;
        st_n = S_FETCH;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_FETCH;
      t <= NSLOT'(1);
      ie <= 1'b1;
    end else begin
      state <= st_n;
      if (last) t <= NSLOT'(1);
      else if (state != S_HALT) t <= t << 1;
      if (take_int) ie <= 1'b0;
      else if (end_instr && !irq) ie <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mar <= '0;
      mbr <= '0;
      ir <= '0;
      pc_q <= '0;
      r1 <= '0;
    end else begin
      if (mar_pc) mar <= pc_q;
      else if (mar_ir) mar <= ir[AW-1:0];
      else if (mar_save) mar <= SAVE_ADDR;

      if (rd) mbr <= mem_rdata;
      else if (mbr_pc) mbr <= DW'(pc_q);
      else if (mbr_inc) mbr <= mbr + 1'b1;

      if (ir_all) ir <= mbr;
      else if (ir_addr) ir[AW-1:0] <= mbr[AW-1:0];

      if (pc_isr) pc_q <= ISR_ADDR;
      else if (pc_jump) pc_q <= ir[AW-1:0];
      else if (pc_inc) pc_q <= pc_q + 1'b1;

      if (acc_add) r1 <= r1 + mbr;
    end
  end

  assign mem_addr = mar;
  assign mem_wdata = mbr;
  assign mem_rd = rd;
  assign mem_wr = wr;
  assign pc = pc_q;
  assign acc = r1;
  assign halted = state == S_HALT;
endmodule

// File: rtl/hw_sequencer_chk.sv
module hw_sequencer_chk #(
  parameter int AW = 11
) (
  input logic clk,
  input logic rst,
  input logic mem_rd,
  input logic mem_wr,
  input logic halted,
  input logic [AW-1:0] pc
);
  // R11
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr));
  // R11
  no_back_read_chk: assert property (@(posedge clk) disable iff (rst) mem_rd |=> !mem_rd);
  // R11
  no_back_write_chk: assert property (@(posedge clk) disable iff (rst) mem_wr |=> !mem_wr);
  // R10
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst) halted |=> halted && $stable(pc));
  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst) halted |-> !mem_rd && !mem_wr);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> pc == '0 && !halted && !mem_rd);
endmodule

bind hw_sequencer hw_sequencer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_wr(mem_wr), .halted(halted), .pc(pc)
);

// File: tb/test_hw_sequencer.sv
module test_hw_sequencer;
  localparam logic [10:0] SAVE = 11'h7FE;
  localparam logic [10:0] ISR = 11'h7C0;

  logic clk = 0, rst = 1, irq = 0;
  logic [10:0] mem_addr, pc;
  logic [15:0] mem_wdata, mem_rdata, acc;
  logic mem_rd, mem_wr, halted;

  logic [15:0] mem [2048];
  logic [15:0] img [2048];
  logic [15:0] g [2048];
  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  hw_sequencer i_hw_sequencer (
    .clk(clk), .rst(rst), .irq(irq), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .pc(pc), .acc(acc),
    .halted(halted)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired act %0d exp <150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %0h exp %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ins(input int op, input bit ind, input int a);
    return {op[3:0], ind, a[10:0]};
  endfunction

  task automatic clear_img();
    for (int i = 0; i < 2048; i++) img[i] = 16'h0000;
  endtask

  task automatic do_reset();
    rst = 1;
    for (int i = 0; i < 2048; i++) mem[i] <= img[i];
    @(negedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  task automatic run_to_halt(output int n);
    n = 0;
    for (int k = 0; k < 4000; k++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (halted) break;
    end
  endtask

  task automatic ref_run(output logic [15:0] racc, output logic [10:0] rpc, output int rcyc);
    logic [15:0] w;
    logic [10:0] a;
    int op;
    for (int i = 0; i < 2048; i++) g[i] = img[i];
    racc = 0; rpc = 0; rcyc = 0;
    for (int s = 0; s < 1000; s++) begin
      w = g[rpc];
      rpc = rpc + 11'd1;
      rcyc += 3;
      op = int'(w[15:12]);
      if (op == 0) break;
      if (op > 3) continue;
      a = w[10:0];
      if (w[11]) begin rcyc += 3; a = g[a][10:0]; end
      if (op == 1) begin racc = racc + g[a]; rcyc += 3; end
      else if (op == 2) begin
        g[a] = g[a] + 16'd1; rcyc += 4;
        if (g[a] == 0) rpc = rpc + 11'd1;
      end else begin
        g[a] = {5'b0, rpc}; rpc = a + 11'd1; rcyc += 3;
      end
    end
  endtask

  task automatic run_and_compare(input string tag);
    logic [15:0] racc;
    logic [10:0] rpc;
    int rcyc, n;
    bit memok;
    ref_run(racc, rpc, rcyc);
    run_to_halt(n);
    chk(n == rcyc, {tag, " R2 cycles"}, n, rcyc);
    chk(acc == racc, {tag, " R4 acc"}, acc, racc);
    chk(pc == rpc, {tag, " R5 pc"}, pc, rpc);
    memok = 1;
    for (int i = 0; i < 2048; i++) if (mem[i] !== g[i]) memok = 0;
    chk(memok, {tag, " R6 memory"}, 0, 0);
  endtask

  initial begin
    int n, lim, hit;
    logic [10:0] hpc;
    // R1 reset state
    clear_img();
    img[0] = ins(1, 0, 16'h200); img[16'h200] = 16'h1234;
    do_reset();
    chk(pc == 0 && acc == 0 && !mem_rd && !mem_wr && !halted, "R1 reset", {pc, acc[4:0]}, 0);
    // R2 fetch timing
    @(posedge clk); @(negedge clk);
    chk(mem_rd && mem_addr == 0 && pc == 0, "R2 fetch read slot", {mem_rd, mem_addr}, 32'h800);
    @(posedge clk); @(negedge clk);
    chk(!mem_rd && pc == 1, "R2 pc increment", {mem_rd, pc}, 1);
    run_to_halt(n);
    chk(acc == 16'h1234, "R4 add", acc, 16'h1234);

    // R5 ISZ with skip
    clear_img();
    img[0] = ins(2, 0, 16'h200); img[1] = ins(1, 0, 16'h201); img[2] = ins(1, 0, 16'h202);
    img[16'h200] = 16'hFFFF; img[16'h201] = 7; img[16'h202] = 3;
    do_reset(); run_and_compare("isz skip");
    chk(mem[16'h200] == 0 && acc == 3, "R5 skip", acc, 3);
    // R5 ISZ without skip
    img[16'h200] = 16'h0005;
    do_reset(); run_and_compare("isz noskip");
    chk(mem[16'h200] == 6 && acc == 10, "R5 noskip", acc, 10);

    // R6 BSA direct
    clear_img();
    img[0] = ins(3, 0, 16'h100); img[16'h101] = ins(1, 0, 16'h200); img[16'h200] = 5;
    do_reset(); run_and_compare("bsa");
    chk(mem[16'h100] == 1 && pc == 11'h103 && acc == 5, "R6 bsa", mem[16'h100], 1);

    // R7 indirect with junk upper bits
    clear_img();
    img[0] = ins(1, 1, 16'h300); img[16'h300] = 16'hF205; img[16'h205] = 9;
    img[1] = ins(3, 1, 16'h301); img[16'h301] = 16'hA120; img[16'h121] = ins(1, 0, 16'h205);
    do_reset(); run_and_compare("indirect");
    chk(acc == 18 && mem[16'h120] == 2 && mem[16'h300] == 16'hF205, "R7 indirect", acc, 18);

    // R3 no-op opcodes: no access, fetch only
    clear_img();
    img[0] = 16'h4FFF; img[1] = 16'hF800; img[2] = 16'h8201;
    do_reset(); run_to_halt(n);
    chk(n == 12 && acc == 0 && pc == 4, "R3 noop", n, 12);

    // R8 R9 interrupt with request held high
    clear_img();
    for (int i = 0; i < 64; i++) img[i] = 16'h4000;
    img[ISR] = ins(1, 0, 16'h200);
    for (int i = 1; i < 32; i++) img[ISR + i] = 16'h4000;
    img[16'h200] = 16'h0011;
    irq = 1;
    do_reset(); run_to_halt(n);
    chk(mem[SAVE] == 1, "R8 saved return", mem[SAVE], 1);
    chk(acc == 16'h11 && pc == ISR + 33, "R9 single entry", acc, 16'h11);

    // R10 halted ignores request
    hpc = pc; hit = 0;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); @(negedge clk);
      if (mem_wr || mem_rd || pc != hpc || !halted) hit = 1;
    end
    chk(hit == 0, "R10 halt hold", hit, 0);

    // R9 re-enable after request low, second entry
    irq = 1;
    do_reset();
    lim = 0;
    while (pc != ISR && lim < 100) begin @(posedge clk); @(negedge clk); lim++; end
    irq = 0;
    repeat (12) begin @(posedge clk); @(negedge clk); end
    irq = 1;
    run_to_halt(n);
    irq = 0;
    chk(acc == 16'h22, "R9 re-arm", acc, 16'h22);
    chk(mem[SAVE] > ISR && mem[SAVE] <= ISR + 32, "R8 second save", mem[SAVE], ISR + 1);

    // R4 R5 R7 constrained random programs
    void'($urandom(32'h5EED));
    for (int p = 0; p < 20; p++) begin
      int len;
      clear_img();
      for (int k = 0; k < 8; k++) img[16'h200 + k] = ($urandom % 3 == 0) ? 16'hFFFF : 16'($urandom);
      for (int k = 0; k < 4; k++) img[16'h300 + k] = {5'($urandom), 11'h200 + 11'($urandom % 8)};
      len = 4 + int'($urandom % 11);
      for (int i = 0; i < len; i++) begin
        int r; bit ind;
        r = int'($urandom % 3);
        ind = 1'($urandom);
        if (r == 2) img[i] = {4'(4 + $urandom % 12), 12'($urandom)};
        else img[i] = ins(r + 1, ind, ind ? 16'h300 + int'($urandom % 4) : 16'h200 + int'($urandom % 8));
      end
      do_reset();
      run_and_compare("random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule